// File: doc/BRIEF.md
# Two-Wire Serial Target Engine with Clock Stretching

This block is the target (slave) side of a two-wire serial bus. It samples the clock and data lines through synchronizers and pulls either line low through open-drain style outputs; it never drives a line high. It finds START and STOP conditions on the bus. It takes the first byte after each START as an address and compares it with a 7-bit address that the host programs. It can also answer the all-zero broadcast address if the host allows that.

Once addressed, the block moves bytes between the bus and a host-side data register. While the host has not yet serviced that register, the block holds the clock line low. On a read it waits for the host to write the next byte. On a write it waits for the host to read the byte just received. Enable bits and sticky status flags form a plain register-style host interface. The block only answers as a target on the bus.

Top module: `twi_target_core`

## Requirements
- R1: After reset both line-drive outputs are low (lines released), and `byte_done`, `tx_mode`, `addr_match`, `gc_match`, `stop_seen` and `nack_seen` are all 0.
- R2: A START is SDA falling while SCL is high. The next 8 bits, MSB first, form the address byte. Bits 7..1 are the address. Bit 0 is the direction: 1 means the master reads and the block transmits (`tx_mode`=1); 0 means the master writes (`tx_mode`=0).
- R3: If the address bits equal `own_addr` and `ack_en`=1, the block pulls SDA low on the ninth clock and sets `addr_match`. If not, it leaves SDA released and ignores the bus until the next START or STOP.
- R4: The address byte 0x00 is acknowledged only when `gc_en`=1. It then sets `gc_match`. With `gc_en`=0 it is not acknowledged.
- R5: Each byte received after an acknowledged write address appears on `rx_data`, MSB first. On its ninth clock the block sends ACK (SDA low) when `ack_en`=1 and NACK (SDA released) when `ack_en`=0.
- R6: After the ninth clock of each received byte, SCL stays pulled low until the host pulses `rx_rd`. The release follows on the next cycle.
- R7: In transmit mode, SCL is pulled low before each byte until the host pulses `tx_wr`. The byte on `tx_data` is then shifted out MSB first.
- R8: When the master answers a transmitted byte with NACK (SDA high on the ninth clock), the block sets `nack_seen`, releases both lines and no longer stretches until the next START.
- R9: A STOP (SDA rising while SCL is high) sets `stop_seen`, releases both lines and clears `addr_match` and `gc_match`. A START clears `stop_seen` and `nack_seen`.
- R10: While `core_en`=0 the block releases both lines and does not respond to any address.
- R11: `byte_done` is 1 exactly while the block is stretching SCL and waiting for host service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Enables the target engine |
| own_addr | input | 7 | Programmed 7-bit target address |
| gc_en | input | 1 | Allows the all-zero broadcast address |
| ack_en | input | 1 | Allows ACK on address and received bytes |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| tx_data | input | 8 | Next byte to transmit |
| tx_wr | input | 1 | One-cycle pulse: host wrote `tx_data` |
| rx_data | output | 8 | Last received byte |
| rx_rd | input | 1 | One-cycle pulse: host read `rx_data` |
| byte_done | output | 1 | Host service pending, clock being stretched |
| tx_mode | output | 1 | Direction of the current transfer (1 = transmit) |
| addr_match | output | 1 | Own address acknowledged |
| gc_match | output | 1 | Broadcast address acknowledged |
| stop_seen | output | 1 | STOP observed since the last START |
| nack_seen | output | 1 | Master answered a transmitted byte with NACK |

## Verification
The hardest case to reach is a repeated START that arrives while the block is stretching SCL after a received byte. The SDA edge can only count as a START once the host has read the byte and SCL has been allowed to rise. The bench drives a master model onto wired-AND lines that always waits for SCL to go high. A separate host process services the data register only after a long delay. Because of that delay, the repeated START has to pass through the stretch release before the new address phase. Stretching is confirmed by checking, at the moment the host services the block, that the clock line is still held low.

// File: rtl/twi_pkg.sv
package twi_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_END,
        S_ADDR_ACK,
        S_RX,
        S_RX_END,
        S_RX_ACK,
        S_RX_HOLD,
        S_TX_HOLD,
        S_TX,
        S_TX_ACK,
        S_WAIT
    } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = d;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINES = 2;

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    prev_t prev_d, prev_q;
    logic scl;

    assign raw = {scl_i, sda_i};

    for (genvar i = 0; i < NLINES; i++) begin : g_sync
        twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[i]),
            .q    (synced[i])
        );
    end

    assign scl = synced[1];
    assign sda = synced[0];

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl;
        prev_d.sda = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_rise = scl & ~prev_q.scl;
    assign scl_fall = ~scl & prev_q.scl;
    assign start_ev = scl & prev_q.scl & prev_q.sda & ~sda;
    assign stop_ev  = scl & prev_q.scl & ~prev_q.sda & sda;
endmodule

// File: rtl/twi_target_core.sv
module twi_target_core
    import twi_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_rd,
    output logic              byte_done,
    output logic              tx_mode,
    output logic              addr_match,
    output logic              gc_match,
    output logic              stop_seen,
    output logic              nack_seen
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        twi_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
        logic              rw;
        logic              scl_lo;
        logic              sda_lo;
        logic              am;
        logic              gm;
        logic              stp;
        logic              nk;
        logic              mack;
    } regs_t;

    regs_t d, q;
    logic sda, scl_rise, scl_fall, start_ev, stop_ev;
    logic own_hit, gc_hit;

    twi_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda     (sda),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    assign own_hit = (q.sh[DATA_W-1:1] == own_addr);
    assign gc_hit  = gc_en && (q.sh == '0);

    always_comb begin
        d = q;
        if (!core_en) begin
            d.st     = S_IDLE;
            d.scl_lo = 1'b0;
            d.sda_lo = 1'b0;
        end else if (stop_ev) begin
            d.st     = S_IDLE;
            d.scl_lo = 1'b0;
            d.sda_lo = 1'b0;
            d.stp    = 1'b1;
            d.am     = 1'b0;
            d.gm     = 1'b0;
        end else if (start_ev) begin
            d.st     = S_ADDR;
            d.cnt    = '0;
            d.scl_lo = 1'b0;
            d.sda_lo = 1'b0;
            d.stp    = 1'b0;
            d.nk     = 1'b0;
            d.am     = 1'b0;
            d.gm     = 1'b0;
        end else begin
            unique case (q.st)
                S_ADDR, S_RX: if (scl_rise) begin
                    d.sh = {q.sh[DATA_W-2:0], sda};
                    if (q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        d.st  = (q.st == S_ADDR) ? S_ADDR_END : S_RX_END;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                S_ADDR_END: if (scl_fall) begin
                    if ((own_hit || gc_hit) && ack_en) begin
                        d.sda_lo = 1'b1;
                        d.am     = own_hit;
                        d.gm     = gc_hit;
                        d.rw     = q.sh[0];
                        d.st     = S_ADDR_ACK;
                    end else begin
                        d.st = S_WAIT;
                    end
                end
                S_ADDR_ACK: if (scl_fall) begin
                    d.sda_lo = 1'b0;
                    d.cnt    = '0;
                    if (q.rw) begin
                        d.st     = S_TX_HOLD;
                        d.scl_lo = 1'b1;
                    end else begin
                        d.st = S_RX;
                    end
                end
                S_RX_END: if (scl_fall) begin
                    d.rx     = q.sh;
                    d.sda_lo = ack_en;
                    d.st     = S_RX_ACK;
                end
                S_RX_ACK: if (scl_fall) begin
                    d.sda_lo = 1'b0;
                    d.scl_lo = 1'b1;
                    d.st     = S_RX_HOLD;
                end
                S_RX_HOLD: if (rx_rd) begin
                    d.scl_lo = 1'b0;
                    d.cnt    = '0;
                    d.st     = S_RX;
                end
                S_TX_HOLD: if (tx_wr) begin
                    d.sh     = tx_data;
                    d.sda_lo = ~tx_data[DATA_W-1];
                    d.scl_lo = 1'b0;
                    d.cnt    = '0;
                    d.st     = S_TX;
                end
                S_TX: if (scl_fall) begin
                    if (q.cnt == LAST_BIT) begin
                        d.sda_lo = 1'b0;
                        d.cnt    = '0;
                        d.st     = S_TX_ACK;
                    end else begin
                        d.sh     = q.sh << 1;
                        d.sda_lo = ~q.sh[DATA_W-2];
                        d.cnt    = q.cnt + CNT_W'(1);
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) d.mack = ~sda;
                    if (scl_fall) begin
                        if (q.mack) begin
                            d.st     = S_TX_HOLD;
                            d.scl_lo = 1'b1;
                        end else begin
                            d.nk = 1'b1;
                            d.st = S_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_drive_low = q.scl_lo;
    assign sda_drive_low = q.sda_lo;
    assign rx_data       = q.rx;
    assign byte_done     = (q.st == S_RX_HOLD) || (q.st == S_TX_HOLD);
    assign tx_mode       = q.rw;
    assign addr_match    = q.am;
    assign gc_match      = q.gm;
    assign stop_seen     = q.stp;
    assign nack_seen     = q.nk;

    // R10: disabled engine lets go of both lines
    p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> (!scl_drive_low && !sda_drive_low));

    // R6: host read ends the receive stretch
    p_rx_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && byte_done && !tx_mode && rx_rd && !stop_ev && !start_ev) |=> !scl_drive_low);

    // R7: host write ends the transmit stretch
    p_tx_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && byte_done && tx_mode && tx_wr && !stop_ev && !start_ev) |=> !scl_drive_low);

    // R4: broadcast match only when allowed
    p_gc_allowed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_match) |-> $past(gc_en));

    // R8: master NACK leaves the lines free
    p_nack_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_seen) |-> (!sda_drive_low && !scl_drive_low));

    // R9: STOP releases and flags
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && stop_ev) |=> (!scl_drive_low && !sda_drive_low && stop_seen && !addr_match));

    // R11: pending service always goes with a stretched clock
    p_done_stretch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> scl_drive_low);
endmodule

// File: tb/sim_twi_target_core.sv
`timescale 1ns/1ps
module sim_twi_target_core;
    localparam int HALF     = 6;
    localparam int HOST_DLY = 40;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_en = 1'b1;
    logic [6:0] own_addr = OWN;
    logic gc_en = 1'b0;
    logic ack_en = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic scl_dl, sda_dl;
    logic [7:0] tx_data = 8'h00;
    logic tx_wr = 1'b0;
    logic rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic byte_done, tx_mode, addr_match, gc_match, stop_seen, nack_seen;
    wire scl_line = m_scl & ~scl_dl;
    wire sda_line = m_sda & ~sda_dl;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] exp_rx[$];
    logic [7:0] tx_src[$];
    logic [7:0] exp_tx[$];

    always #4 clk = ~clk;

    twi_target_core u0 (
        .clk(clk), .rst_n(rst_n), .core_en(core_en), .own_addr(own_addr),
        .gc_en(gc_en), .ack_en(ack_en), .scl_i(scl_line), .sda_i(sda_line),
        .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .tx_data(tx_data),
        .tx_wr(tx_wr), .rx_data(rx_data), .rx_rd(rx_rd), .byte_done(byte_done),
        .tx_mode(tx_mode), .addr_match(addr_match), .gc_match(gc_match),
        .stop_seen(stop_seen), .nack_seen(nack_seen)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half_bit();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        m_sda = b;
        half_bit();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        half_bit();
        r = sda_line;
        m_scl = 1'b0;
        half_bit();
    endtask

    task automatic m_start();
        m_sda = 1'b1;
        half_bit();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        half_bit();
        m_sda = 1'b0;
        half_bit();
        m_scl = 1'b0;
        half_bit();
    endtask

    task automatic m_stop();
        m_sda = 1'b0;
        half_bit();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        half_bit();
        m_sda = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic m_write(input logic [7:0] b, output logic nack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, nack);
    endtask

    task automatic m_read(input logic nack_out, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        clk_bit(nack_out, r);
    endtask

    // driver side of the scoreboard: master writes a byte, host must see it
    task automatic send_byte(input logic [7:0] b, input logic exp_nack, input string req);
        logic nk;
        exp_rx.push_back(b);
        m_write(b, nk);
        chk(nk == exp_nack, req, nk, exp_nack);
    endtask

    task automatic host_load(input logic [7:0] b);
        tx_src.push_back(b);
        exp_tx.push_back(b);
    endtask

    // monitor side: master reads a byte and compares it with the queue head
    task automatic recv_byte(input logic nack_out);
        logic [7:0] v, e;
        m_read(nack_out, v);
        if (exp_tx.size() == 0) chk(1'b0, "R7 unexpected byte", v, 0);
        else begin
            e = exp_tx.pop_front();
            chk(v == e, "R7 transmitted byte", v, e);
        end
    endtask

    // host process: services the data register after a delay
    initial begin
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && byte_done) begin
                repeat (HOST_DLY) @(negedge clk);
                chk(scl_dl == 1'b1, tx_mode ? "R7 stretch before byte" : "R6 stretch after byte", scl_dl, 1);
                chk(byte_done == 1'b1, "R11 pending while stretched", byte_done, 1);
                if (tx_mode) begin
                    tx_data = (tx_src.size() != 0) ? tx_src.pop_front() : 8'h00;
                    tx_wr = 1'b1;
                    @(negedge clk);
                    tx_wr = 1'b0;
                end else begin
                    if (exp_rx.size() == 0) chk(1'b0, "R5 unexpected byte", rx_data, 0);
                    else begin
                        e = exp_rx.pop_front();
                        chk(rx_data == e, "R5 received byte", rx_data, e);
                    end
                    rx_rd = 1'b1;
                    @(negedge clk);
                    rx_rd = 1'b0;
                end
                @(negedge clk);
                chk(scl_dl == 1'b0, "R6 R7 release after service", scl_dl, 0);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic nk;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!scl_dl && !sda_dl, "R1 lines released", {scl_dl, sda_dl}, 0);
        chk({byte_done, tx_mode, addr_match, gc_match, stop_seen, nack_seen} == 6'b0,
            "R1 flags clear", {byte_done, tx_mode, addr_match, gc_match, stop_seen, nack_seen}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3 R5 R6: write to own address
        m_start();
        m_write({OWN, 1'b0}, nk);
        chk(nk == 1'b0, "R3 own address ACK", nk, 0);
        chk(addr_match == 1'b1, "R3 addr_match", addr_match, 1);
        chk(tx_mode == 1'b0, "R2 write direction", tx_mode, 0);
        send_byte(8'h96, 1'b0, "R5 ACK byte 1");
        send_byte(8'h01, 1'b0, "R5 ACK byte 2");
        send_byte(8'hFF, 1'b0, "R5 ACK byte 3");
        m_stop();
        chk(stop_seen == 1'b1, "R9 stop_seen", stop_seen, 1);
        chk(addr_match == 1'b0, "R9 match cleared", addr_match, 0);
        chk(!scl_dl && !sda_dl, "R9 lines released", {scl_dl, sda_dl}, 0);
        chk(exp_rx.size() == 0, "R5 all bytes delivered", exp_rx.size(), 0);
        chk(byte_done == 1'b0, "R11 idle after stop", byte_done, 0);

        // R3: foreign address ignored
        m_start();
        chk(stop_seen == 1'b0, "R9 start clears stop_seen", stop_seen, 0);
        m_write({7'h15, 1'b0}, nk);
        chk(nk == 1'b1, "R3 foreign address NACK", nk, 1);
        chk(addr_match == 1'b0, "R3 no match", addr_match, 0);
        m_write(8'h00, nk);
        chk(nk == 1'b1 && byte_done == 1'b0, "R3 ignored until stop", {nk, byte_done}, 2'b10);
        m_stop();

        // R4: broadcast address
        m_start();
        m_write(8'h00, nk);
        chk(nk == 1'b1 && gc_match == 1'b0, "R4 broadcast refused", {nk, gc_match}, 2'b10);
        m_stop();
        gc_en = 1'b1;
        m_start();
        m_write(8'h00, nk);
        chk(nk == 1'b0, "R4 broadcast ACK", nk, 0);
        chk(gc_match == 1'b1 && addr_match == 1'b0, "R4 gc_match", {gc_match, addr_match}, 2'b10);
        send_byte(8'h5A, 1'b0, "R5 broadcast data");
        m_stop();
        gc_en = 1'b0;

        // R5: acknowledge disabled for data
        m_start();
        m_write({OWN, 1'b0}, nk);
        chk(nk == 1'b0, "R3 address ACK", nk, 0);
        ack_en = 1'b0;
        send_byte(8'hC3, 1'b1, "R5 NACK when ack_en=0");
        ack_en = 1'b1;
        m_stop();

        // R2 R7 R8: read from the block
        host_load(8'hA5);
        host_load(8'h3C);
        m_start();
        m_write({OWN, 1'b1}, nk);
        chk(nk == 1'b0, "R3 read address ACK", nk, 0);
        chk(tx_mode == 1'b1, "R2 read direction", tx_mode, 1);
        recv_byte(1'b0);
        recv_byte(1'b1);
        repeat (6) @(negedge clk);
        chk(nack_seen == 1'b1, "R8 nack_seen", nack_seen, 1);
        chk(!scl_dl && !sda_dl && !byte_done, "R8 released, no stretch", {scl_dl, sda_dl, byte_done}, 0);
        m_stop();
        chk(nack_seen == 1'b1, "R9 nack kept over stop", nack_seen, 1);

        // R9: repeated START out of a receive stretch
        m_start();
        chk(nack_seen == 1'b0 && stop_seen == 1'b0, "R9 start clears flags", {nack_seen, stop_seen}, 0);
        m_write({OWN, 1'b0}, nk);
        send_byte(8'h77, 1'b0, "R5 before repeated start");
        host_load(8'h11);
        m_start();
        m_write({OWN, 1'b1}, nk);
        chk(nk == 1'b0 && tx_mode == 1'b1, "R2 repeated start read", {nk, tx_mode}, 2'b01);
        recv_byte(1'b1);
        m_stop();

        // R10: engine disabled
        core_en = 1'b0;
        m_start();
        m_write({OWN, 1'b0}, nk);
        chk(nk == 1'b1, "R10 no response when off", nk, 1);
        chk(!scl_dl && !sda_dl, "R10 lines released", {scl_dl, sda_dl}, 0);
        m_stop();
        core_en = 1'b1;

        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule